// File: doc/BRIEF.md
# Byte-Lane SRAM Datapath with Pipelined and Flow-Through Read

This block is the storage and data path that sits behind a synchronous SRAM bus controller. It holds a word array split into byte lanes. Each lane carries a parameterised number of bits, so a nine-bit lane can hold eight data bits and one parity bit. The controller tells the block on each clock edge whether an access starts, and gives the address, the write controls and the write data. The block decodes per-lane write strobes from two levels of control. One is a global write strobe that covers the whole word. The other is a byte-write qualifier combined with one strobe per lane.

Write data and lane strobes are captured on the edge that accepts the write and are committed to the array on the following edge. Read data comes out through one of two output stages, chosen by a static mode pin. In registered mode the data passes through an output register and appears one clock after the address was taken. In flow-through mode that register is bypassed. The driver-enable output models the bus drivers. It is gated at once by an output-enable input that needs no clock, and it is forced off whenever the accepted access is a write. A sleep input blocks new accesses and turns the drivers off, while the array keeps its contents.

Top module: `bytelane_sram_core`

## Requirements
- R1: With `gwr_n` low on an accepted cycle, every lane of the addressed word is written with the matching lane of `wdata`, whatever `bwr_n` and `lane_n` are. Lane i occupies bits [i*LANE_W +: LANE_W].
- R2: With `gwr_n` high and `bwr_n` low, exactly the lanes whose `lane_n` bit is 0 are written, and the other lanes keep their old value.
- R3: With `gwr_n` high and either `bwr_n` high or `lane_n` all ones, an accepted cycle is a read and the array is unchanged.
- R4: A write accepted on one edge is visible to a read accepted on the very next edge at the same address, in both output modes.
- R5: With `flow_n` high (registered mode), a read accepted on edge k that follows a write drives nothing after edge k and drives the read word after edge k+1.
- R6: With `flow_n` low (flow-through mode), a read accepted on edge k drives the read word from edge k on.
- R7: After an edge that accepts a write, `dq_oe` is 0 even when `oe_n` is 0.
- R8: `oe_n` high forces `dq_oe` to 0 without waiting for a clock edge, and `oe_n` low restores it at once.
- R9: With `cyc_vld` low, no access is taken. The address and access kind are held, a held read keeps driving the same word, and write controls present on such cycles change nothing.
- R10: While `sleep` is 1, no access is accepted and `dq_oe` is 0. Array contents are retained across sleep.
- R11: After synchronous reset (`rst_n` low on an edge) no access is active and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of control state |
| cyc_vld | input | 1 | An access starts on this edge |
| addr | input | ADDR_W | Word address of the access |
| gwr_n | input | 1 | Global write, active low, writes all lanes |
| bwr_n | input | 1 | Byte-write qualifier, active low |
| lane_n | input | LANES | Per-lane write strobes, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low, acts without a clock |
| flow_n | input | 1 | 0 = flow-through read, 1 = registered read |
| sleep | input | 1 | Low-power hold: no accesses, drivers off |
| dq_o | output | LANES*LANE_W | Read data toward the bus drivers |
| dq_oe | output | 1 | 1 = bus drivers enabled |

## Verification
The collision that matters is a write commit and a read of the same word on one edge. The commit from the input register lands on the same edge that accepts the next read. The bench provokes it by issuing a write and then, with no gap, a read of the same address, for all 64 combinations of the global, byte and lane strobes and in both output modes. Each read-back is judged against a shadow array updated with the lane rule, so a stale word, a lane written wrongly or a one-cycle shift in the output stage shows up as a mismatch.

// File: rtl/sram_dp_pkg.sv
// Shared types for the byte-lane SRAM datapath.
// Assumes: nothing beyond IEEE 1800-2017.
package sram_dp_pkg;

    // Kind of the most recently accepted access.
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_e;

endpackage

// File: rtl/lane_wr_decode.sv
// Per-lane write strobe decoder.
// Turns the global write, the byte-write qualifier and the lane strobes
// (all active low) into active-high lane write enables and a write flag.
// Assumes: inputs are already synchronous to the accepting edge.
module lane_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] we_lane,
    output logic             wr_req
);

    // One enable per lane: global write wins, else qualified lane strobe.
    for (genvar g = 0; g < LANES; g++) begin : g_dec
        assign we_lane[g] = ~gwr_n | (~bwr_n & ~lane_n[g]);
    end

    // The cycle is a write when any lane is enabled.
    assign wr_req = |we_lane;

endmodule

// File: rtl/sram_lane_array.sv
// Word array stored as independent lane memories.
// Each lane has its own write enable. Reads are combinational from
// the address supplied.
// Assumes: one write port and one read port; contents are not reset.
module sram_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Commit one lane of the pending write.
        always_ff @(posedge clk) begin
            if (wr_en[g]) begin
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        // Lane slice of the read word.
        assign rd_word[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/rd_out_stage.sv
// Read output stage with registered and flow-through paths.
// Registered mode delays both data and the read flag by one edge.
// Driver enable is gated combinationally by oe_n and sleep, and is
// forced off whenever the current access is a write.
// Assumes: flow_n is static while a read is being driven.
module rd_out_stage #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    logic [DATA_W-1:0] pipe_data;
    logic              pipe_rd;
    logic              rd_live;

    // Output register of the registered read path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_data <= '0;
            pipe_rd   <= 1'b0;
        end else begin
            pipe_data <= rd_word;
            pipe_rd   <= acc_rd;
        end
    end

    // Pick the path and the matching read flag.
    always_comb begin
        if (flow_n) begin
            dq_o    = pipe_data;
            rd_live = pipe_rd;
        end else begin
            dq_o    = rd_word;
            rd_live = acc_rd;
        end
    end

    // Driver enable: needs a live read, no write, awake, oe_n low.
    assign dq_oe = rd_live & ~acc_wr & ~sleep & ~oe_n;

endmodule

// File: rtl/bytelane_sram_core.sv
// Top of the byte-lane SRAM datapath.
// Registers the address and access kind on accepted edges, holds a
// pending write in the input register for one edge, and feeds the
// lane array and the read output stage.
// Assumes: the controller presents one access per accepted edge;
// address sequencing is done outside this block.
module bytelane_sram_core
    import sram_dp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cyc_vld,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    gwr_n,
    input  logic                    bwr_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    input  logic                    flow_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe
);

    localparam int DATA_W = LANES * LANE_W;

    logic [LANES-1:0]  we_lane;
    logic              wr_req;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    acc_e              acc_q;
    logic [LANES-1:0]  wq_en;
    logic [ADDR_W-1:0] wq_addr;
    logic [DATA_W-1:0] wq_data;
    logic [DATA_W-1:0] rd_word;

    lane_wr_decode #(.LANES(LANES)) u_dec (
        .gwr_n   (gwr_n),
        .bwr_n   (bwr_n),
        .lane_n  (lane_n),
        .we_lane (we_lane),
        .wr_req  (wr_req)
    );

    // An access is taken only when offered and the block is awake.
    assign accept = cyc_vld & ~sleep;

    // Address and access-kind register; held while no access is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            acc_q  <= ACC_IDLE;
        end else if (accept) begin
            addr_q <= addr;
            acc_q  <= wr_req ? ACC_WR : ACC_RD;
        end
    end

    // Input register: captures a write, commits it on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wq_en   <= '0;
            wq_addr <= '0;
            wq_data <= '0;
        end else begin
            wq_en <= accept ? we_lane : '0;
            if (accept && wr_req) begin
                wq_addr <= addr;
                wq_data <= wdata;
            end
        end
    end

    sram_lane_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wq_en),
        .wr_addr (wq_addr),
        .wr_data (wq_data),
        .rd_addr (addr_q),
        .rd_word (rd_word)
    );

    rd_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .flow_n  (flow_n),
        .oe_n    (oe_n),
        .sleep   (sleep),
        .acc_rd  (acc_q == ACC_RD),
        .acc_wr  (acc_q == ACC_WR),
        .rd_word (rd_word),
        .dq_o    (dq_o),
        .dq_oe   (dq_oe)
    );

endmodule

// File: rtl/sram_core_chk.sv
// Port-level properties of the byte-lane SRAM datapath, bound to the top.
// Assumes: synchronous active-low reset; flow_n changes only while idle.
module sram_core_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cyc_vld,
    input logic                    gwr_n,
    input logic                    bwr_n,
    input logic [LANES-1:0]        lane_n,
    input logic                    oe_n,
    input logic                    flow_n,
    input logic                    sleep,
    input logic [LANES*LANE_W-1:0] dq_o,
    input logic                    dq_oe
);

    logic wr_seen;
    logic prev_vld;

    // Write request as seen from the pins.
    assign wr_seen = ~gwr_n | (~bwr_n & (lane_n != {LANES{1'b1}}));

    // Remember whether the previous edge offered an access.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_vld <= 1'b0;
        else        prev_vld <= cyc_vld;
    end

    // R7: an accepted write turns the drivers off on the next cycle.
    p_wr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_vld && !sleep && wr_seen) |=> !dq_oe);

    // R8: output enable high means no drive.
    p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    // R10: sleeping means no drive.
    p_sleep_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);

    // R6: a flow-through read drives on the next cycle.
    p_flow_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_n && cyc_vld && !sleep && !wr_seen) |=> (dq_oe || oe_n || sleep || flow_n));

    // R9: a held read keeps its data stable.
    p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && !cyc_vld && !prev_vld) |=> (!dq_oe || $stable(dq_o) || !$stable(flow_n)));

endmodule

bind bytelane_sram_core sram_core_chk #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc_vld (cyc_vld),
    .gwr_n   (gwr_n),
    .bwr_n   (bwr_n),
    .lane_n  (lane_n),
    .oe_n    (oe_n),
    .flow_n  (flow_n),
    .sleep   (sleep),
    .dq_o    (dq_o),
    .dq_oe   (dq_oe)
);

// File: tb/tb_bytelane_sram_core.sv
`timescale 1ns/1ps
module tb_bytelane_sram_core;

    localparam int AW = 4;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cyc_vld;
    logic [AW-1:0] addr;
    logic          gwr_n;
    logic          bwr_n;
    logic [NL-1:0] lane_n;
    logic [DW-1:0] wdata;
    logic          oe_n;
    logic          flow_n;
    logic          sleep;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    logic [DW-1:0] shadow [NW];
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    always #4 clk = ~clk;

    bytelane_sram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .addr(addr),
        .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n), .wdata(wdata),
        .oe_n(oe_n), .flow_n(flow_n), .sleep(sleep),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [DW:0] act, input logic [DW:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        cyc_vld = 1'b0; gwr_n = 1'b1; bwr_n = 1'b1; lane_n = '1;
    endtask

    // Drive a write and update the shadow with the lane rule (R1, R2).
    task automatic put_wr(input logic [AW-1:0] a, input logic g, input logic b,
                          input logic [NL-1:0] l, input logic [DW-1:0] d);
        cyc_vld = 1'b1; addr = a; gwr_n = g; bwr_n = b; lane_n = l; wdata = d;
        for (int i = 0; i < NL; i++) begin
            if (!g || (!b && !l[i])) shadow[a][i*LW +: LW] = d[i*LW +: LW];
        end
    endtask

    // Drive a read, using either read encoding (R3).
    task automatic put_rd(input logic [AW-1:0] a, input bit alt);
        cyc_vld = 1'b1; addr = a; gwr_n = 1'b1;
        bwr_n  = alt ? 1'b0 : 1'b1;
        lane_n = alt ? '1 : 4'b0101;
    endtask

    function automatic logic [DW:0] drv(input logic oe, input logic [DW-1:0] d);
        return {oe, d};
    endfunction

    initial begin
        rst_n = 1'b0; addr = '0; wdata = '0; oe_n = 1'b0; flow_n = 1'b0; sleep = 1'b0;
        idle_in();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(dq_oe == 1'b0, "R11 reset drive", {36'd0, dq_oe}, '0);
        step();
        check(dq_oe == 1'b0, "R11 idle after reset", {36'd0, dq_oe}, '0);

        // Preload every word with a global write; lane strobes vary (R1).
        for (int a = 0; a < NW; a++) begin
            put_wr(AW'(a), 1'b0, a[0], NL'(a * 7), DW'(64'h1_2345_6789 * (a + 3)));
            step();
        end
        idle_in();
        step();
        for (int a = 0; a < NW; a++) begin
            put_rd(AW'(a), a[1]);
            step();
            check(dq_oe && dq_o == shadow[a], "R1 global write read-back",
                  drv(dq_oe, dq_o), drv(1'b1, shadow[a]));
        end
        idle_in();
        step();

        // Write then read the same word back-to-back, all strobe combos.
        for (int m = 0; m < 2; m++) begin
            flow_n = m[0];
            step();
            for (int c = 0; c < 64; c++) begin
                logic [AW-1:0] a;
                logic [DW-1:0] d;
                logic [DW-1:0] exp;
                string         tag;
                a = AW'(c) ^ AW'(m * 5);
                d = DW'(64'h9E37_79B9_7F4A * (c + 1)) ^ (m != 0 ? DW'(64'h5_A5A5_A5A5) : '0);
                if (!c[5])                  tag = "R1/R4";
                else if (!c[4] && c[3:0] != 4'hF) tag = "R2/R4";
                else                        tag = "R3/R4";
                put_wr(a, c[5], c[4], c[3:0], d);
                exp = shadow[a];
                step();
                if (!c[5] || (!c[4] && c[3:0] != 4'hF))
                    check(dq_oe == 1'b0, "R7 drive off after write", {36'd0, dq_oe}, '0);
                put_rd(a, c[0]);
                step();
                if (m == 0) begin
                    check(dq_oe && dq_o == exp, {tag, " R6 flow read"}, drv(dq_oe, dq_o), drv(1'b1, exp));
                    idle_in();
                end else begin
                    if (!c[5] || (!c[4] && c[3:0] != 4'hF))
                        check(dq_oe == 1'b0, "R5 no drive one edge early", {36'd0, dq_oe}, '0);
                    idle_in();
                    step();
                    check(dq_oe && dq_o == exp, {tag, " R5 registered read"}, drv(dq_oe, dq_o), drv(1'b1, exp));
                end
                step();
                check(dq_oe && dq_o == exp, "R9 held read", drv(dq_oe, dq_o), drv(1'b1, exp));
            end
            oe_n = 1'b1;
            #1;
            check(dq_oe == 1'b0, "R8 oe_n high", {36'd0, dq_oe}, '0);
            oe_n = 1'b0;
            #1;
            check(dq_oe == 1'b1, "R8 oe_n low", {36'd0, dq_oe}, {36'd0, 1'b1});
            @(negedge clk);
        end

        // Write controls with cyc_vld low change nothing (R9).
        flow_n = 1'b0;
        addr = 4'd3; gwr_n = 1'b0; wdata = '1; cyc_vld = 1'b0;
        step();
        step();
        put_rd(4'd3, 1'b0);
        step();
        check(dq_oe && dq_o == shadow[3], "R9 no write while idle", drv(dq_oe, dq_o), drv(1'b1, shadow[3]));
        idle_in();
        step();

        // Sleep blocks access, turns drivers off, keeps contents (R10).
        sleep = 1'b1;
        #1;
        check(dq_oe == 1'b0, "R10 drive off in sleep", {36'd0, dq_oe}, '0);
        cyc_vld = 1'b1; addr = 4'd5; gwr_n = 1'b0; wdata = '0;
        step();
        step();
        check(dq_oe == 1'b0, "R10 still off in sleep", {36'd0, dq_oe}, '0);
        idle_in();
        sleep = 1'b0;
        step();
        put_rd(4'd5, 1'b1);
        step();
        check(dq_oe && dq_o == shadow[5], "R10 contents kept", drv(dq_oe, dq_o), drv(1'b1, shadow[5]));
        idle_in();
        step();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule